// File: doc/BRIEF.md
# Paged Byte ROM Reader on an I/O Bus

This block puts a slow, byte-wide, data-only ROM behind three registers on a processor I/O bus. Software first writes a 2-bit page number to one register. It then writes the 16-bit low half of the byte address to a second register. That second write captures the full 18-bit location and starts a fixed discharge access. Three processor clocks later, the addressed byte is latched into a result register. Software reads the byte through the third register.

The ROM covers locations 0x00000 up to 0x37FFF. Pages 0 to 2 are full, and page 3 holds only its lower half. The array is a synthesizable table computed from the address, with a seed that can be set as a parameter. A `busy` output is high while an access is in flight. A new low-address write during an access drops the old access and starts the timing again. The ROM is never an instruction source. It only answers the result register.

Top module: `pdrom_reader`

## Requirements
- R1: After synchronous reset the result register holds 0x00 and `busy` is low.
- R2: A write (`io_wr`) to I/O address 0x2C takes `io_wdata[15:0]` as address bits 15:0 and starts an access at {page, low}. `busy` is high for exactly the three clock cycles that follow that write edge.
- R3: The result register changes only on the third clock edge after the start. Until then, reads return the byte latched before.
- R4: A read (`io_rd`) at I/O address 0x00 returns the result register on `io_rdata`. With no read, or a read at any other address, `io_rdata` is 0x00. The byte stored at address a is ((a[7:0] XOR a[15:8]) + {a[17:16], 6'b0}) mod 256, XOR SEED (default 0x5A).
- R5: A write to I/O address 0x08 stores `io_wdata[1:0]` as the page, address bits 17:16. It starts no access: `busy` stays low and the result register keeps its value.
- R6: An access uses the page held at its start. A page write during the access does not change the byte it returns.
- R7: Page 3 locations with low address at or above 0x8000 lie outside the ROM and return 0x00. Page 3 low address 0x7FFF is still inside.
- R8: A low-address write while `busy` is high abandons the running access. `busy` then lasts three more cycles, and only the new location's byte is latched. This holds even when the new write falls in the old access's final cycle.
- R9: Writes to any other I/O address start nothing and leave the result register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O register address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| busy | output | 1 | Access in flight |

## Verification
Two functions can fall on the same edge: the capture at the end of an access's third cycle, and a new low-address write that restarts the sequence. The bench waits exactly two clocks after a start and then issues the next low-address write, so the restart lands on the capture edge. It then confirms three things: the abandoned byte never appears, `busy` stays high for three more cycles, and the new byte arrives on the third edge. A second overlap is also exercised. A read of the result register is sampled during the capture cycle, and it must still show the previous byte.

// File: rtl/pdrom_pkg.sv
package pdrom_pkg;

    localparam int IO_AW   = 8;
    localparam int WORD_W  = 16;
    localparam int PAGE_W  = 2;
    localparam int BYTE_W  = 8;
    localparam int ROM_AW  = WORD_W + PAGE_W;

    localparam logic [IO_AW-1:0] REG_RESULT = 8'h00;
    localparam logic [IO_AW-1:0] REG_PAGE   = 8'h08;
    localparam logic [IO_AW-1:0] REG_LOW    = 8'h2C;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [WORD_W-1:0] low;
    } rom_loc_t;

    // Computed array content: one byte per 18-bit location.
    function automatic logic [BYTE_W-1:0] rom_content(input rom_loc_t loc,
                                                      input logic [BYTE_W-1:0] seed);
        logic [BYTE_W-1:0] mix;
        mix = (loc.low[7:0] ^ loc.low[15:8]) + {loc.page, 6'd0};
        return mix ^ seed;
    endfunction

endpackage

// File: rtl/pdrom_regs.sv
module pdrom_regs
    import pdrom_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic                io_wr,
    input  logic [WORD_W-1:0]   io_wdata,
    output logic                start,
    output rom_loc_t            acc_loc
);
    logic [PAGE_W-1:0] page_q;
    rom_loc_t          acc_q;
    logic              wr_page;

    assign wr_page = io_wr && (io_addr == REG_PAGE);
    assign start   = io_wr && (io_addr == REG_LOW);
    assign acc_loc = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            acc_q  <= '0;
        end else begin
            if (wr_page)
                page_q <= io_wdata[PAGE_W-1:0];
            if (start) begin
                acc_q.page <= page_q;
                acc_q.low  <= io_wdata;
            end
        end
    end

    // R5: a page write never starts an access
    a_r5_page_no_start: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == REG_PAGE) |-> !start);

    // R6: the snapshot only moves when an access starts
    a_r6_snapshot_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(acc_q));

endmodule

// File: rtl/pdrom_seq.sv
module pdrom_seq #(
    parameter int ACCESS_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic capture
);
    localparam int CW = $clog2(ACCESS_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(ACCESS_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy    = (cnt_q != '0);
    // Last discharge cycle latches, unless a restart abandons it.
    assign capture = (cnt_q == CW'(1)) && !start;

    // R2: a start always yields a busy cycle next
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R8: capture ends the access
    a_r8_capture_ends: assert property (@(posedge clk) disable iff (rst)
        capture |=> !busy);

    // R9: without a start, an idle sequencer stays idle
    a_r9_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (!start && !busy) |=> !busy);

endmodule

// File: rtl/pdrom_array.sv
module pdrom_array
    import pdrom_pkg::*;
#(
    parameter int unsigned        DEPTH = 32'h38000,
    parameter logic [BYTE_W-1:0]  SEED  = 8'h5A
) (
    input  rom_loc_t            loc,
    output logic [BYTE_W-1:0]   rdata
);
    localparam logic [ROM_AW:0] LIMIT = (ROM_AW+1)'(DEPTH);

    logic in_range;

    assign in_range = ({1'b0, loc} < LIMIT);
    assign rdata    = in_range ? rom_content(loc, SEED) : '0;

endmodule

// File: rtl/pdrom_reader.sv
module pdrom_reader
    import pdrom_pkg::*;
#(
    parameter int              ACCESS_CYC = 3,
    parameter int unsigned     DEPTH      = 32'h38000,
    parameter logic [7:0]      SEED       = 8'h5A
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [7:0]   io_addr,
    input  logic         io_wr,
    input  logic         io_rd,
    input  logic [15:0]  io_wdata,
    output logic [7:0]   io_rdata,
    output logic         busy
);
    logic              start;
    logic              capture;
    rom_loc_t          acc_loc;
    logic [BYTE_W-1:0] rom_byte;
    logic [BYTE_W-1:0] result_q;

    pdrom_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .start    (start),
        .acc_loc  (acc_loc)
    );

    pdrom_seq #(.ACCESS_CYC(ACCESS_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .busy    (busy),
        .capture (capture)
    );

    pdrom_array #(.DEPTH(DEPTH), .SEED(SEED)) u_array (
        .loc   (acc_loc),
        .rdata (rom_byte)
    );

    always_ff @(posedge clk) begin
        if (rst)
            result_q <= '0;
        else if (capture)
            result_q <= rom_byte;
    end

    assign io_rdata = (io_rd && io_addr == REG_RESULT) ? result_q : '0;

    // R3: the result register only moves on a capture
    a_r3_result_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(result_q));

    // R4: nothing is driven outside a result read
    a_r4_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && io_addr == REG_RESULT) |-> (io_rdata == '0));

endmodule

// File: tb/pdrom_reader_tb.sv
module pdrom_reader_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  io_addr;
    logic        io_wr;
    logic        io_rd;
    logic [15:0] io_wdata;
    logic [7:0]  io_rdata;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pdrom_reader u_dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .busy(busy)
    );

    function automatic logic [7:0] expect_byte(input logic [1:0] pg, input logic [15:0] lo);
        logic [7:0] m;
        if (pg == 2'd3 && lo >= 16'h8000) return 8'h00;
        m = (lo[7:0] ^ lo[15:8]) + {pg, 6'd0};
        return m ^ 8'h5A;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0; io_addr = 8'h00; io_wdata = 16'h0000;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        io_addr = a; io_rd = 1'b1;
        #1 v = io_rdata;
        io_rd = 1'b0; io_addr = 8'h00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] prev;
        logic [15:0] lows [8];
        lows = '{16'h0000, 16'h0001, 16'h00FF, 16'h1234,
                 16'h7FFF, 16'h8000, 16'hABCD, 16'hFFFF};
        rst = 1'b1; io_addr = 0; io_wr = 0; io_rd = 0; io_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(8'h00, v);
        check("R1 result after reset", v, 8'h00);
        check("R1 busy after reset", busy, 1'b0);
        prev = 8'h00;

        // Sweep all pages and a spread of low addresses.
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 8; i++) begin
                wr(8'h08, 16'(p));
                check("R5 page write idle", busy, 1'b0);
                wr(8'h2C, lows[i]);
                check("R2 busy cycle 1", busy, 1'b1);
                rd(8'h00, v);
                check("R3 old byte cycle 1", v, prev);
                @(negedge clk);
                check("R2 busy cycle 2", busy, 1'b1);
                @(negedge clk);
                check("R2 busy cycle 3", busy, 1'b1);
                rd(8'h00, v);
                check("R3 old byte in capture cycle", v, prev);
                @(negedge clk);
                check("R2 busy released", busy, 1'b0);
                rd(8'h00, v);
                prev = expect_byte(2'(p), lows[i]);
                if (p == 3 && lows[i] >= 16'h8000)
                    check("R7 out of range byte", v, prev);
                else
                    check("R4 ROM byte", v, prev);
            end
        end

        // R7: highest valid page 3 location
        wr(8'h08, 16'h0003);
        wr(8'h2C, 16'h7FFF);
        repeat (3) @(negedge clk);
        rd(8'h00, v);
        prev = expect_byte(2'd3, 16'h7FFF);
        check("R7 last valid location", v, prev);

        // R4: read at another address gives zero
        rd(8'h08, v);
        check("R4 read of page reg quiet", v, 8'h00);
        io_addr = 8'h00; #1;
        check("R4 no read strobe quiet", io_rdata, 8'h00);

        // R5: page-only write leaves result and busy alone
        wr(8'h08, 16'h0001);
        @(negedge clk);
        check("R5 no busy after page write", busy, 1'b0);
        rd(8'h00, v);
        check("R5 result unchanged", v, prev);

        // R9: write to unrelated address
        wr(8'h10, 16'h4321);
        check("R9 no busy", busy, 1'b0);
        repeat (3) @(negedge clk);
        rd(8'h00, v);
        check("R9 result unchanged", v, prev);

        // R6: page change mid-access does not affect it
        wr(8'h08, 16'h0001);
        wr(8'h2C, 16'h3C3C);
        wr(8'h08, 16'h0002);
        @(negedge clk);
        @(negedge clk);
        check("R6 busy released", busy, 1'b0);
        rd(8'h00, v);
        prev = expect_byte(2'd1, 16'h3C3C);
        check("R6 byte uses start page", v, prev);

        // R8: restart one cycle into an access
        wr(8'h08, 16'h0000);
        wr(8'h2C, 16'h1111);
        wr(8'h2C, 16'h2288);
        check("R8 busy after restart", busy, 1'b1);
        @(negedge clk);
        @(negedge clk);
        rd(8'h00, v);
        check("R8 old access not captured", v, prev);
        check("R8 still busy", busy, 1'b1);
        @(negedge clk);
        rd(8'h00, v);
        prev = expect_byte(2'd0, 16'h2288);
        check("R8 restarted byte", v, prev);

        // R8: restart lands on the capture edge of the first access
        wr(8'h2C, 16'h0F0F);
        @(negedge clk);
        @(negedge clk);
        wr(8'h2C, 16'h5A01);
        check("R8 busy after edge collision", busy, 1'b1);
        rd(8'h00, v);
        check("R8 abandoned byte dropped", v, prev);
        @(negedge clk);
        @(negedge clk);
        rd(8'h00, v);
        check("R8 still old before new capture", v, prev);
        @(negedge clk);
        check("R8 busy released after collision", busy, 1'b0);
        rd(8'h00, v);
        prev = expect_byte(2'd0, 16'h5A01);
        check("R8 collision new byte", v, prev);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule